// File: doc/BRIEF.md
# Mixed-Storage Scrambled-Order Counter

This block is a three-bit counter that steps through a fixed, non-binary order of codes, one step for each clock edge on which its count enable is high. The three state bits sit in three different kinds of storage element. The most significant bit is a set/reset stage. The middle bit is a J/K stage. The least significant bit is a toggle stage. Each stage gets its own drive equations, worked out from how that element behaves. None of them is a plain data input that has been converted into another form.

The state bits go straight to the output as the present count. A synchronous clear, and a synchronous active-low reset, both return the counter to its start code of zero. All stages are edge triggered, so the feedback through the drive logic can cause at most one transition per clock edge.

Top module: `mixed_seq_counter`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `count_q` becomes 3'b000 at that edge, whatever `count_en` and `clear` are.
- R2: When `clear` is sampled high with `rst_n` high, `count_q` becomes 3'b000 at that edge from any of the eight states. Clear wins over `count_en`.
- R3: When `count_en` is sampled low with `clear` low and `rst_n` high, all three bits of `count_q` keep their values.
- R4: On each enabled edge, `count_q` (bit 2 first, bit 0 last) moves through the codes 0, 1, 5, 4, 2, 6, 7, 3 and then back to 0. Every enabled step changes the output.
- R5: Bit 2 is held in a set/reset stage. It is driven with set = bit1 XOR bit0 and reset = NOT set, so the stage never sees set and reset high together. On an enabled step the new bit 2 therefore equals bit1 XOR bit0 of the old state.
- R6: Bit 1 is held in a J/K stage, with J = bit2 AND NOT bit0 and K = NOT bit2 AND bit0. The stage holds, clears, sets or inverts according to J and K.
- R7: Bit 0 is held in a toggle stage. Starting from state 0 and going round the cycle, its toggle drive is 1, 0, 1, 0, 0, 1, 0, 1, so bit 0 inverts exactly on the steps out of codes 0, 5, 6 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to code 0 |
| count_en | input | 1 | Count pulse; the counter advances one step on an edge where it is high |
| clear | input | 1 | Synchronous clear to code 0; takes priority over count_en |
| count_q | output | 3 | Present state; bit 2 is the set/reset stage, bit 1 the J/K stage, bit 0 the toggle stage |

## Verification
The bench takes the counter round its full cycle twice. At every step it compares the whole code with the expected order. It also checks each bit against the rule of its own storage element, so a wrong J/K or toggle drive shows up as a bad bit even where the code merely looks out of place. In every one of the eight states it holds `count_en` low for two cycles; a stage that ignored the enable would drift to a neighbouring code. It clears from every state with the enable also high, and a design that gave the enable priority would land on the successor code instead of zero. It also applies reset in the middle of counting.

// File: rtl/mixed_seq_pkg.sv
// Shared types for the mixed-storage counter.
// Assumes a three-bit state: bit 2 set/reset, bit 1 J/K, bit 0 toggle.
package mixed_seq_pkg;
    localparam int STATE_W = 3;
    localparam logic [STATE_W-1:0] HOME_CODE = '0;

    typedef logic [STATE_W-1:0] state_t;

    // Drive bundle produced by the excitation logic for the three stages
    typedef struct packed {
        logic set_hi;
        logic rst_hi;
        logic j_in;
        logic k_in;
        logic tog;
    } drive_t;
endpackage

// File: rtl/seq_excite.sv
// Excitation logic: derives each stage's drive from the present state.
// Assumes state bit 2 = set/reset stage, bit 1 = J/K, bit 0 = toggle.
module seq_excite
    import mixed_seq_pkg::*;
(
    input  state_t cur,
    output drive_t drv
);
    logic b2, b1, b0;
    assign b2 = cur[2];
    assign b1 = cur[1];
    assign b0 = cur[0];

    // Compute the drive of every stage from the present code
    always_comb begin
        drv.set_hi = b1 ^ b0;
        drv.rst_hi = ~(b1 ^ b0);
        drv.j_in   = b2 & ~b0;
        drv.k_in   = ~b2 & b0;
        drv.tog    = ~(b2 ^ b1) ^ b0;
    end
endmodule

// File: rtl/sr_cell.sv
// Set/reset storage element with synchronous reset, clear and enable.
// Assumes its driver never raises set and reset together.
module sr_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic s_in,
    input  logic r_in,
    output logic q
);
    // Hold, set or reset on an enabled edge; clear and reset go to 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= 1'b0;
        else if (en) begin
            case ({s_in, r_in})
                2'b10:   q <= 1'b1;
                2'b01:   q <= 1'b0;
                default: q <= q;
            endcase
        end
    end

    // R5
    sr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !(s_in && r_in));
endmodule

// File: rtl/jk_cell.sv
// J/K storage element with synchronous reset, clear and enable.
// Assumes all four J/K combinations are legal (hold, clear, set, invert).
module jk_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic j,
    input  logic k,
    output logic q
);
    // Apply the J/K rule on an enabled edge; clear and reset go to 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= 1'b0;
        else if (en) begin
            case ({j, k})
                2'b00: q <= q;
                2'b01: q <= 1'b0;
                2'b10: q <= 1'b1;
                2'b11: q <= ~q;
            endcase
        end
    end

    // R6
    jk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && k && !j) |=> !q);
endmodule

// File: rtl/tog_cell.sv
// Toggle storage element with synchronous reset, clear and enable.
// Assumes the drive is valid whenever en is high.
module tog_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic t,
    output logic q
);
    // Invert on an enabled edge with t high; clear and reset go to 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= 1'b0;
        else if (en && t)
            q <= ~q;
    end

    // R7
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && !t) |=> $stable(q));
endmodule

// File: rtl/mixed_seq_counter.sv
// Top: three-bit counter in the order 0,1,5,4,2,6,7,3 built from
// set/reset, J/K and toggle stages. Assumes synchronous reset and clear.
module mixed_seq_counter
    import mixed_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         clear,
    output logic [2:0]   count_q
);
    state_t cur;
    drive_t drv;

    seq_excite u_excite (
        .cur (cur),
        .drv (drv)
    );

    sr_cell u_bit2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .en    (count_en),
        .s_in  (drv.set_hi),
        .r_in  (drv.rst_hi),
        .q     (cur[2])
    );

    jk_cell u_bit1 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .en    (count_en),
        .j     (drv.j_in),
        .k     (drv.k_in),
        .q     (cur[1])
    );

    tog_cell u_bit0 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .en    (count_en),
        .t     (drv.tog),
        .q     (cur[0])
    );

    // Present state goes straight out as the count
    assign count_q = cur;

    // R1
    reset_home_chk: assert property (@(posedge clk)
        !rst_n |=> (count_q == HOME_CODE));

    // R2
    clear_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == HOME_CODE));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !count_en) |=> $stable(count_q));

    // R4
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && count_en) |=> (count_q != $past(count_q)));
endmodule

// File: tb/mixed_seq_counter_test.sv
module mixed_seq_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       count_en = 1'b0;
    logic       clear = 1'b0;
    logic [2:0] count_q;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    mixed_seq_counter uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .clear    (clear),
        .count_q  (count_q)
    );

    always #5 clk = ~clk;

    // Index of a code in the count order 0,1,5,4,2,6,7,3
    function automatic int pos_of(input logic [2:0] c);
        logic [2:0] order [8] = '{3'd0, 3'd1, 3'd5, 3'd4, 3'd2, 3'd6, 3'd7, 3'd3};
        for (int i = 0; i < 8; i++) if (order[i] == c) return i;
        return -1;
    endfunction

    function automatic logic [2:0] succ(input logic [2:0] c);
        logic [2:0] order [8] = '{3'd0, 3'd1, 3'd5, 3'd4, 3'd2, 3'd6, 3'd7, 3'd3};
        return order[(pos_of(c) + 1) % 8];
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs just after a falling edge, return at the next falling edge
    task automatic cycle(input logic rn, input logic en, input logic clr);
        rst_n = rn;
        count_en = en;
        clear = clr;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] prev;
        logic [2:0] exp;
        logic jv, kv, tv;
        @(negedge clk);
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        check("R1 reset state", count_q, 3'd0);

        // Two full laps, whole code and per-bit rules
        for (int i = 0; i < 16; i++) begin
            prev = count_q;
            cycle(1'b1, 1'b1, 1'b0);
            check("R4 order", count_q, succ(prev));
            check("R5 set/reset bit", {2'b00, count_q[2]}, {2'b00, prev[1] ^ prev[0]});
            jv = prev[2] & ~prev[0];
            kv = ~prev[2] & prev[0];
            exp[1] = (jv & ~prev[1]) | (~kv & prev[1]);
            check("R6 J/K bit", {2'b00, count_q[1]}, {2'b00, exp[1]});
            tv = (prev == 3'd0) || (prev == 3'd5) || (prev == 3'd6) || (prev == 3'd3);
            check("R7 toggle bit", {2'b00, count_q[0]}, {2'b00, prev[0] ^ tv});
        end

        // Hold with enable low in each state
        for (int s = 0; s < 8; s++) begin
            prev = count_q;
            cycle(1'b1, 1'b0, 1'b0);
            cycle(1'b1, 1'b0, 1'b0);
            check("R3 hold", count_q, prev);
            cycle(1'b1, 1'b1, 1'b0);
        end

        // Clear from every state, enable also high
        for (int s = 0; s < 8; s++) begin
            cycle(1'b1, 1'b0, 1'b1);
            for (int k = 0; k < s; k++) cycle(1'b1, 1'b1, 1'b0);
            check("R4 reach", {2'b00, pos_of(count_q) == s}, 3'd1);
            cycle(1'b1, 1'b1, 1'b1);
            check("R2 clear", count_q, 3'd0);
        end

        // Reset in the middle of counting
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b1, 1'b0);
        check("R4 mid", count_q, 3'd4);
        cycle(1'b0, 1'b1, 1'b0);
        check("R1 mid reset", count_q, 3'd0);
        cycle(1'b1, 1'b1, 1'b0);
        check("R4 restart", count_q, 3'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule